// File: doc/BRIEF.md
# GPIO Port Register Block with Atomic Pin Set/Clear

This block is a sixteen-pin general-purpose I/O port that sits on a simple 32-bit memory-mapped bus. The bus has an address, a write enable, write data and read data. Software configures each pin through four configuration registers: a two-bit mode field per pin, an output type bit, a two-bit speed field and a two-bit pull field. Software drives pins through an output data register and reads the pads through a synchronised input register.

A separate write-only set/clear register lets software raise some pins and lower others in one bus write. No read-modify-write is needed, so an interrupting writer cannot lose an update to a pin it did not name. Software that needs to toggle pins or replace all outputs at once can still write the output data register directly.

A peripheral clock-enable input gates every register write. The block turns the stored mode, type and output bits into per-pin output, output-enable and alternate-function select signals. The speed and pull fields are passed out unchanged.

Top module: `gpio_port`

## Requirements
- R1: After reset, every stored register is zero. Every defined offset then reads zero and no pad output is enabled.
- R2: The mode (offset 0x00), output type (0x04), speed (0x08) and pull (0x0C) registers are written and read back at their offsets. The mode field of pin n is bits [2n+1:2n]. Bits [31:16] of the output type register ignore writes and read as zero. The speed and pull fields appear on speedCfg and pullCfg.
- R3: A write to the output data register (0x14) replaces all sixteen output bits with write data [15:0]. Bits [31:16] read as zero, and padOut follows the stored bits.
- R4: In a write to the set/clear register (0x18), a 1 in bit n (n = 0..15) sets output bit n and a 1 in bit n+16 clears it. Zero bits leave their outputs unchanged, so pins not named in the write keep their value.
- R5: When one write sets and clears the same pin, the set wins and the output bit becomes 1.
- R6: The set/clear register always reads 0x00000000. Any offset other than 0x00, 0x04, 0x08, 0x0C, 0x10, 0x14 and 0x18 also reads zero.
- R7: The input register (0x10) shows padIn through a two-flop synchroniser. A pad change becomes readable after the second rising clock edge, and not after the first. Writes to it are ignored, and bits [31:16] read zero.
- R8: While clkEn is low, bus writes to every register are ignored and leave all stored values unchanged.
- R9: padOe[n] can be high only when mode field n is 01. altSel[n] is high exactly when mode field n is 10.
- R10: With output type bit n at 0 (push-pull), an output-mode pin is always enabled. With the bit at 1 (open-drain), the pin is enabled only while its output bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clkEn | input | 1 | Peripheral clock enable; low blocks all writes |
| busAddr | input | 8 | Byte address offset within the port |
| busWe | input | 1 | Write strobe, sampled on the rising edge |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr (combinational) |
| padIn | input | 16 | Pad input levels (asynchronous) |
| padOut | output | 16 | Pad output levels |
| padOe | output | 16 | Pad output enables |
| altSel | output | 16 | Per-pin alternate-function select |
| speedCfg | output | 32 | Per-pin speed fields |
| pullCfg | output | 32 | Per-pin pull fields |

## Verification
The assertions check four rules on every cycle:
- after a set/clear write, named pins take the requested level and unnamed pins keep theirs;
- an enabled open-drain pin never drives high;
- the set/clear offset never returns data;
- pad outputs never move after a cycle with the clock enable low.

The bench scenarios cover the rest. These are the two-edge synchroniser latency, the set-over-clear priority and the exact read-back of every register against a reference model. They also cover the reserved and undefined offsets reading zero, and long random mixes of direct writes and set/clear writes, including writes with the clock enable low.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int OFS_MODE   = 'h00;
  localparam int OFS_OTYPE  = 'h04;
  localparam int OFS_SPEED  = 'h08;
  localparam int OFS_PULL   = 'h0C;
  localparam int OFS_IN     = 'h10;
  localparam int OFS_OUT    = 'h14;
  localparam int OFS_SETCLR = 'h18;

  typedef struct packed {
    logic wrMode;
    logic wrOtype;
    logic wrSpeed;
    logic wrPull;
    logic wrOut;
    logic wrSetClr;
  } gpioStrb_t;

  typedef enum logic [2:0] {
    RD_NONE, RD_MODE, RD_OTYPE, RD_SPEED, RD_PULL, RD_IN, RD_OUT
  } rdSel_t;
endpackage

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
  import gpio_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clkEn,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  output gpioStrb_t         strb,
  output rdSel_t            rdSel
);
  logic wrOk;
  assign wrOk = busWe && clkEn;

  always_comb begin
    strb  = '0;
    rdSel = RD_NONE;
    case (busAddr)
      ADDR_W'(OFS_MODE):   begin rdSel = RD_MODE;  strb.wrMode  = wrOk; end
      ADDR_W'(OFS_OTYPE):  begin rdSel = RD_OTYPE; strb.wrOtype = wrOk; end
      ADDR_W'(OFS_SPEED):  begin rdSel = RD_SPEED; strb.wrSpeed = wrOk; end
      ADDR_W'(OFS_PULL):   begin rdSel = RD_PULL;  strb.wrPull  = wrOk; end
      ADDR_W'(OFS_IN):     rdSel = RD_IN;
      ADDR_W'(OFS_OUT):    begin rdSel = RD_OUT;   strb.wrOut   = wrOk; end
      ADDR_W'(OFS_SETCLR): strb.wrSetClr = wrOk;
      default: ;
    endcase
  end
endmodule

// File: rtl/gpio_datapath.sv
module gpio_datapath
  import gpio_pkg::*;
#(
  parameter int NUM_PINS = 16,
  parameter int DATA_W   = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  gpioStrb_t             strb,
  input  rdSel_t                rdSel,
  input  logic [DATA_W-1:0]     wdata,
  output logic [DATA_W-1:0]     rdata,
  input  logic [NUM_PINS-1:0]   padIn,
  output logic [NUM_PINS-1:0]   padOut,
  output logic [NUM_PINS-1:0]   padOe,
  output logic [NUM_PINS-1:0]   altSel,
  output logic [2*NUM_PINS-1:0] speedCfg,
  output logic [2*NUM_PINS-1:0] pullCfg
);
  localparam int HALF  = DATA_W / 2;
  localparam int FLD_W = 2 * NUM_PINS;

  logic [FLD_W-1:0]    modeReg, speedReg, pullReg;
  logic [NUM_PINS-1:0] otypeReg, outReg, syncA, syncB;
  logic [NUM_PINS-1:0] setMask, clrMask;

  assign setMask = wdata[NUM_PINS-1:0];
  assign clrMask = wdata[HALF +: NUM_PINS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      modeReg  <= '0;
      speedReg <= '0;
      pullReg  <= '0;
      otypeReg <= '0;
      outReg   <= '0;
      syncA    <= '0;
      syncB    <= '0;
    end else begin
      syncA <= padIn;
      syncB <= syncA;
      if (strb.wrMode)  modeReg  <= wdata[FLD_W-1:0];
      if (strb.wrSpeed) speedReg <= wdata[FLD_W-1:0];
      if (strb.wrPull)  pullReg  <= wdata[FLD_W-1:0];
      if (strb.wrOtype) otypeReg <= wdata[NUM_PINS-1:0];
      if (strb.wrOut)
        outReg <= wdata[NUM_PINS-1:0];
      else if (strb.wrSetClr)
        outReg <= (outReg & ~clrMask) | setMask;  // set wins over clear
    end
  end

  always_comb begin
    case (rdSel)
      RD_MODE:  rdata = DATA_W'(modeReg);
      RD_OTYPE: rdata = DATA_W'(otypeReg);
      RD_SPEED: rdata = DATA_W'(speedReg);
      RD_PULL:  rdata = DATA_W'(pullReg);
      RD_IN:    rdata = DATA_W'(syncB);
      RD_OUT:   rdata = DATA_W'(outReg);
      default:  rdata = '0;
    endcase
  end

  for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin
    logic [1:0] fld;
    assign fld       = modeReg[2*n +: 2];
    assign altSel[n] = (fld == 2'b10);
    assign padOut[n] = outReg[n];
    assign padOe[n]  = (fld == 2'b01) && (!otypeReg[n] || !outReg[n]);
  end

  assign speedCfg = speedReg;
  assign pullCfg  = pullReg;

  // R4: every pin named in the set half is high after the write
  a_r4_set_applies: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.wrSetClr && !strb.wrOut) |=> ((outReg & $past(setMask)) == $past(setMask)));

  // R4/R5: pins cleared and not also set are low after the write
  a_r5_clear_applies: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.wrSetClr && !strb.wrOut) |=> ((outReg & $past(clrMask & ~setMask)) == '0));

  // R4: pins not named keep their level
  a_r4_others_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.wrSetClr && !strb.wrOut) |=>
      (((outReg ^ $past(outReg)) & ~$past(setMask | clrMask)) == '0));

  // R10: an enabled open-drain pin never drives high
  a_r10_open_drain: assert property (@(posedge clk) disable iff (!rst_n)
    ((padOe & padOut & otypeReg) == '0));

  // R9: enable only in general output mode
  a_r9_oe_mode: assert property (@(posedge clk) disable iff (!rst_n)
    ((padOe & altSel) == '0));
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_pkg::*;
#(
  parameter int NUM_PINS = 16,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clkEn,
  input  logic [ADDR_W-1:0]     busAddr,
  input  logic                  busWe,
  input  logic [DATA_W-1:0]     busWdata,
  output logic [DATA_W-1:0]     busRdata,
  input  logic [NUM_PINS-1:0]   padIn,
  output logic [NUM_PINS-1:0]   padOut,
  output logic [NUM_PINS-1:0]   padOe,
  output logic [NUM_PINS-1:0]   altSel,
  output logic [2*NUM_PINS-1:0] speedCfg,
  output logic [2*NUM_PINS-1:0] pullCfg
);
  gpioStrb_t strb;
  rdSel_t    rdSel;

  gpio_ctrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .clkEn(clkEn), .busWe(busWe), .busAddr(busAddr), .strb(strb), .rdSel(rdSel)
  );

  gpio_datapath #(.NUM_PINS(NUM_PINS), .DATA_W(DATA_W)) i_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .rdSel(rdSel), .wdata(busWdata),
    .rdata(busRdata), .padIn(padIn), .padOut(padOut), .padOe(padOe),
    .altSel(altSel), .speedCfg(speedCfg), .pullCfg(pullCfg)
  );

  // R8: with the clock enable low, no pad control moves on the next edge
  a_r8_gated_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !clkEn |=> ($stable(padOut) && $stable(padOe) && $stable(altSel)));

  // R6: the set/clear offset never returns data
  always_comb begin
    if (rst_n && busAddr == ADDR_W'(OFS_SETCLR))
      a_r6_setclr_reads_zero: assert (busRdata == '0);
  end
endmodule

// File: tb/test_gpio_port.sv
module test_gpio_port;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0, clkEn = 0, busWe = 0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0, busRdata;
  logic [15:0] padIn = '0, padOut, padOe, altSel;
  logic [31:0] speedCfg, pullCfg;

  int errors = 0, checks = 0;
  bit done = 0;

  logic [31:0] mMode, mSpeed, mPull;
  logic [15:0] mOtype, mOut, mIn;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_port i_gpio_port (
    .clk(clk), .rst_n(rst_n), .clkEn(clkEn), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .padIn(padIn), .padOut(padOut),
    .padOe(padOe), .altSel(altSel), .speedCfg(speedCfg), .pullCfg(pullCfg)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] expRead(logic [7:0] a);
    case (a)
      8'h00: return mMode;
      8'h04: return {16'h0, mOtype};
      8'h08: return mSpeed;
      8'h0C: return mPull;
      8'h10: return {16'h0, mIn};
      8'h14: return {16'h0, mOut};
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [15:0] expOe();
    logic [15:0] r;
    for (int n = 0; n < 16; n++)
      r[n] = (mMode[2*n +: 2] == 2'b01) && (!mOtype[n] || !mOut[n]);
    return r;
  endfunction

  function automatic logic [15:0] expAlt();
    logic [15:0] r;
    for (int n = 0; n < 16; n++) r[n] = (mMode[2*n +: 2] == 2'b10);
    return r;
  endfunction

  task automatic modelWrite(logic [7:0] a, logic [31:0] d, logic en);
    if (!en) return;
    case (a)
      8'h00: mMode  = d;
      8'h04: mOtype = d[15:0];
      8'h08: mSpeed = d;
      8'h0C: mPull  = d;
      8'h14: mOut   = d[15:0];
      8'h18: mOut   = (mOut & ~d[31:16]) | d[15:0];
      default: ;
    endcase
  endtask

  task automatic busWrite(logic [7:0] a, logic [31:0] d, logic en);
    @(negedge clk);
    busAddr = a; busWdata = d; busWe = 1; clkEn = en;
    @(posedge clk);
    modelWrite(a, d, en);
    @(negedge clk);
    busWe = 0; clkEn = 1;
  endtask

  task automatic readCheck(string req, logic [7:0] a);
    @(negedge clk);
    busAddr = a;
    #1;
    check(req, busRdata, expRead(a));
  endtask

  task automatic padCheck(string req);
    check({req, " padOut"}, {16'h0, padOut}, {16'h0, mOut});
    check({req, " padOe"},  {16'h0, padOe},  {16'h0, expOe()});
    check({req, " altSel"}, {16'h0, altSel}, {16'h0, expAlt()});
    check({req, " speed"},  speedCfg, mSpeed);
    check({req, " pull"},   pullCfg,  mPull);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] offs [9];
    offs = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h14, 8'h18, 8'h1C, 8'h40};
    void'($urandom(32'h5EED_1234));
    mMode = 0; mSpeed = 0; mPull = 0; mOtype = 0; mOut = 0; mIn = 0;

    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1; clkEn = 1;

    // R1: reset state
    foreach (offs[i]) readCheck("R1 reset read", offs[i]);
    padCheck("R1 reset");

    // R2: configuration registers; reserved upper otype bits
    busWrite(8'h00, 32'hA5F0_1E69, 1); readCheck("R2 mode", 8'h00);
    busWrite(8'h04, 32'hFFFF_00FF, 1); readCheck("R2 otype upper zero", 8'h04);
    busWrite(8'h08, 32'h1234_5678, 1); readCheck("R2 speed", 8'h08);
    busWrite(8'h0C, 32'h8765_4321, 1); readCheck("R2 pull", 8'h0C);
    padCheck("R2 R9 R10");

    // R3: direct output write
    busWrite(8'h00, 32'h5555_5555, 1);
    busWrite(8'h04, 32'h0, 1);
    busWrite(8'h14, 32'hDEAD_C3A5, 1); readCheck("R3 out", 8'h14);
    padCheck("R3 R10 push-pull");

    // R4: set some, clear others, keep the rest
    busWrite(8'h18, 32'h00F0_0000 | 32'h0000_0102, 1);
    readCheck("R4 set/clear", 8'h14); padCheck("R4");

    // R5: same pin both set and cleared -> set wins
    busWrite(8'h14, 32'h0, 1);
    busWrite(8'h18, 32'h0021_0021, 1);
    check("R5 set priority", {16'h0, padOut}, 32'h0000_0021);
    busWrite(8'h18, 32'h0001_0000, 1);
    check("R5 clear alone", {16'h0, padOut}, 32'h0000_0020);

    // R6: set/clear and undefined offsets read zero
    readCheck("R6 setclr read", 8'h18);
    readCheck("R6 undefined", 8'h1C);
    readCheck("R6 undefined hi", 8'hFC);

    // R10: open-drain enables only when low
    busWrite(8'h04, 32'h0000_FFFF, 1);
    busWrite(8'h14, 32'h0000_0F0F, 1);
    check("R10 open drain oe", {16'h0, padOe}, 32'h0000_F0F0);
    padCheck("R10");

    // R9: alternate mode and input mode never enable
    busWrite(8'h04, 32'h0, 1);
    busWrite(8'h00, 32'hAAAA_0000, 1);
    check("R9 alt sel", {16'h0, altSel}, 32'h0000_FF00);
    check("R9 oe off", {16'h0, padOe}, 32'h0);

    // R8: writes ignored while clock enable low
    busWrite(8'h14, 32'h0000_1234, 0);
    busWrite(8'h18, 32'hFFFF_FFFF, 0);
    busWrite(8'h00, 32'h0, 0);
    readCheck("R8 out held", 8'h14);
    readCheck("R8 mode held", 8'h00);
    padCheck("R8");

    // R7: two-edge synchroniser; input register ignores writes
    @(negedge clk) padIn = 16'hBEEF;
    @(posedge clk); @(negedge clk); #1;
    busAddr = 8'h10; #1;
    check("R7 after one edge", busRdata, 32'h0);
    @(posedge clk); @(negedge clk); mIn = 16'hBEEF;
    readCheck("R7 after two edges", 8'h10);
    busWrite(8'h10, 32'h1111_1111, 1);
    readCheck("R7 write ignored", 8'h10);

    // random mix
    for (int k = 0; k < 600; k++) begin
      logic [7:0]  a;
      logic [31:0] d;
      logic        en;
      a  = offs[$urandom_range(0, 8)];
      d  = $urandom();
      en = ($urandom_range(0, 7) != 0);
      busWrite(a, d, en);
      padCheck(en ? "R4 R3 R9 random" : "R8 random");
      readCheck("R2 R3 R6 random read", offs[$urandom_range(0, 8)]);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule